// File: doc/BRIEF.md
# Lane-wise Saturating Average ALU

This block is a pipelined SIMD arithmetic unit. It takes two packed operand vectors and splits them into lanes of 8, 16 or 32 bits. It applies one of eight lane-wise operations to every lane at once:

- saturating add and subtract;
- truncating and rounded halving add;
- truncating, rounded and rounded-saturated halving subtract;
- round-then-right-shift by a shift amount.

A signedness flag picks sign extension or zero extension of the operands. Every lane computes at twice its width before the result is narrowed or clamped.

A separate helper produces the carry out of bit 31 for a 32-bit add with carry-in, taken over the lowest 32 bits of the operands. One register stage sits between the inputs and the outputs. A valid strobe moves through that stage beside the data. When no valid input arrives, the registered outputs keep their last values.

Top module: `savg_alu`

## Requirements
- R1: Each cycle that `in_valid` is high is followed, one clock later, by `out_valid` high. The `result` and `carry_out` computed from the inputs of that cycle appear at the same time. A cycle with `in_valid` low is followed by `out_valid` low.
- R2: While `in_valid` is low, `result` and `carry_out` keep their previous values, whatever the other inputs do.
- R3: After reset, `out_valid`, `result` and `carry_out` are all 0.
- R4: `lane_sel` picks the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Lane k occupies bits [k*W +: W], and no lane affects another.
- R5: With `signed_mode` = 1, each lane operand is sign-extended to 2W bits. With `signed_mode` = 0 it is zero-extended. All sums and differences are formed at that width.
- R6: Opcode 0 returns a+b and opcode 1 returns a-b, each clamped to the lane range. The range is 0..2^W-1 when unsigned and -2^(W-1)..2^(W-1)-1 when signed.
- R7: Opcode 2 returns (a+b)>>1 and opcode 3 returns (a+b+1)>>1. The shift is arithmetic and the result is truncated to W bits.
- R8: Opcode 4 returns (a-b)>>1 and opcode 5 returns (a-b+1)>>1. The shift is arithmetic and the result is truncated to W bits.
- R9: Opcode 6 returns (a-b+1)>>1 clamped to the lane range of R6.
- R10: Opcode 7 returns (a + 2^(s-1)) >> s for s > 0, and a unchanged for s = 0. The shift is arithmetic. Here s is `shamt` limited to at most W-1.
- R11: `carry_out` is bit 32 of the 33-bit zero-extended sum op_a[31:0] + op_b[31:0] + carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands valid |
| op_a | input | VEC_W | First packed operand |
| op_b | input | VEC_W | Second packed operand |
| opcode | input | 3 | Lane operation, 0..7 |
| signed_mode | input | 1 | 1 signed lanes, 0 unsigned lanes |
| lane_sel | input | 2 | Lane width select |
| shamt | input | 5 | Shift amount for opcode 7 |
| carry_in | input | 1 | Carry input of the 32-bit helper |
| result | output | VEC_W | Registered packed result |
| carry_out | output | 1 | Registered carry of the 32-bit helper |
| out_valid | output | 1 | Result valid |

## Verification
Each lane width, opcode and signedness is driven with operand pairs from an eight-value set per width. The set holds zero, one, two, all ones, all ones minus one, the most negative value, the most positive value and an alternating bit pattern. Lanes receive different pairs inside one vector, so a lane slicing error or cross-lane carry shows up as a mismatch in a single lane. The extreme pairs separate sign from zero extension and show whether clamping is correct at both range ends. They also catch a rounding addend applied to the wrong opcode or at the wrong shift amount. Every shift amount from 0 to 31 is reached, which covers the clamp on s. Idle cycles with changing inputs show that the registered outputs hold.

// File: rtl/savg_pkg.sv
package savg_pkg;
  typedef enum logic [2:0] {
    OP_ADDS   = 3'd0,
    OP_SUBS   = 3'd1,
    OP_AVG    = 3'd2,
    OP_AVGR   = 3'd3,
    OP_NAVG   = 3'd4,
    OP_NAVGR  = 3'd5,
    OP_NAVGRS = 3'd6,
    OP_RSHR   = 3'd7
  } savg_op_e;

  localparam int SH_W = 5;
endpackage

// File: rtl/savg_lane.sv
module savg_lane
  import savg_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0]   a_i,
  input  logic [LW-1:0]   b_i,
  input  savg_op_e        op_i,
  input  logic            sgn_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [LW-1:0]   r_o
);
  localparam int DW = 2 * LW;
  localparam logic signed [DW-1:0] ONE   = DW'(1);
  localparam logic signed [DW-1:0] S_MAX = DW'((65'd1 << (LW - 1)) - 65'd1);
  localparam logic signed [DW-1:0] S_MIN = -S_MAX - ONE;
  localparam logic signed [DW-1:0] U_MAX = DW'((65'd1 << LW) - 65'd1);
  localparam logic [SH_W-1:0]      SH_CAP = SH_W'(LW - 1);

  logic signed [DW-1:0] ea, eb, sum, dif, rnd_add, rsh_v, pick, hi, lo, val;
  logic [SH_W-1:0]      sh_eff;
  logic                 clamp_en;

  always_comb begin
    // widen each operand before any arithmetic
    ea  = {{LW{sgn_i & a_i[LW-1]}}, a_i};
    eb  = {{LW{sgn_i & b_i[LW-1]}}, b_i};
    sum = ea + eb;
    dif = ea - eb;

    sh_eff  = (sh_i > SH_CAP) ? SH_CAP : sh_i;
    rnd_add = '0;
    if (sh_eff != '0) rnd_add = ONE <<< (sh_eff - SH_W'(1));
    rsh_v   = (ea + rnd_add) >>> sh_eff;

    case (op_i)
      OP_ADDS:   pick = sum;
      OP_SUBS:   pick = dif;
      OP_AVG:    pick = sum >>> 1;
      OP_AVGR:   pick = (sum + ONE) >>> 1;
      OP_NAVG:   pick = dif >>> 1;
      OP_NAVGR:  pick = (dif + ONE) >>> 1;
      OP_NAVGRS: pick = (dif + ONE) >>> 1;
      default:   pick = rsh_v;
    endcase

    clamp_en = (op_i == OP_ADDS) || (op_i == OP_SUBS) || (op_i == OP_NAVGRS);
    hi = sgn_i ? S_MAX : U_MAX;
    lo = sgn_i ? S_MIN : '0;
    if (clamp_en && (pick > hi))      val = hi;
    else if (clamp_en && (pick < lo)) val = lo;
    else                              val = pick;
    r_o = val[LW-1:0];
  end
endmodule

// File: rtl/savg_lane_row.sv
module savg_lane_row
  import savg_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  savg_op_e         op_i,
  input  logic             sgn_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [VEC_W-1:0] r_o
);
  localparam int N_LANES = VEC_W / LW;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    savg_lane #(.LW(LW)) u_lane (
      .a_i   (a_i[i*LW +: LW]),
      .b_i   (b_i[i*LW +: LW]),
      .op_i  (op_i),
      .sgn_i (sgn_i),
      .sh_i  (sh_i),
      .r_o   (r_o[i*LW +: LW])
    );
  end
endmodule

// File: rtl/savg_carry32.sv
module savg_carry32 (
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic        c_i,
  output logic        co_o
);
  // carry out of bit 31 means the 33-bit sum exceeds 32 bits
  assign co_o = (({1'b0, a_i} + {1'b0, b_i} + {32'd0, c_i}) > 33'h0_FFFF_FFFF);
endmodule

// File: rtl/savg_alu.sv
module savg_alu
  import savg_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [2:0]       opcode,
  input  logic             signed_mode,
  input  logic [1:0]       lane_sel,
  input  logic [4:0]       shamt,
  input  logic             carry_in,
  output logic [VEC_W-1:0] result,
  output logic             carry_out,
  output logic             out_valid
);
  localparam int N_WIDTHS = 3;

  logic [1:0]       rst_sync;
  logic             rst_n_q;
  logic [VEC_W-1:0] row_res [N_WIDTHS];
  logic [VEC_W-1:0] res_sel, res_d, res_q;
  logic             co_c, co_d, co_q, vld_d, vld_q;
  savg_op_e         op_e;

  // reset asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_q = rst_sync[1];

  assign op_e = savg_op_e'(opcode);

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    savg_lane_row #(.VEC_W(VEC_W), .LW(8 << g)) u_row (
      .a_i   (op_a),
      .b_i   (op_b),
      .op_i  (op_e),
      .sgn_i (signed_mode),
      .sh_i  (shamt),
      .r_o   (row_res[g])
    );
  end

  savg_carry32 u_carry (
    .a_i  (op_a[31:0]),
    .b_i  (op_b[31:0]),
    .c_i  (carry_in),
    .co_o (co_c)
  );

  always_comb begin
    case (lane_sel)
      2'd0:    res_sel = row_res[0];
      2'd1:    res_sel = row_res[1];
      default: res_sel = row_res[2];
    endcase
    res_d = in_valid ? res_sel : res_q;
    co_d  = in_valid ? co_c    : co_q;
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      res_q <= '0;
      co_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      co_q  <= co_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign carry_out = co_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/savg_alu_chk.sv
module savg_alu_chk #(
  parameter int VEC_W = 64
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             in_valid,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic [2:0]       opcode,
  input logic             signed_mode,
  input logic [1:0]       lane_sel,
  input logic [VEC_W-1:0] result,
  input logic             carry_out,
  input logic             out_valid
);
  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);

  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(result) && $stable(carry_out)));

  // R6
  uadd_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && opcode == 3'd0 && !signed_mode && lane_sel == 2'd0)
      |=> (result[7:0] >= $past(op_a[7:0])));

  // R6
  usub_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && opcode == 3'd1 && !signed_mode && lane_sel == 2'd0)
      |=> (result[7:0] <= $past(op_a[7:0])));

  // R7
  uavg_between_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && opcode == 3'd2 && !signed_mode && lane_sel == 2'd0)
      |=> ((result[7:0] >= (($past(op_a[7:0]) < $past(op_b[7:0])) ? $past(op_a[7:0]) : $past(op_b[7:0])))
        && (result[7:0] <= (($past(op_a[7:0]) < $past(op_b[7:0])) ? $past(op_b[7:0]) : $past(op_a[7:0])))));
endmodule

bind savg_alu savg_alu_chk #(.VEC_W(VEC_W)) i_chk (
  .clk         (clk),
  .rst_ok      (rst_n_q),
  .in_valid    (in_valid),
  .op_a        (op_a),
  .op_b        (op_b),
  .opcode      (opcode),
  .signed_mode (signed_mode),
  .lane_sel    (lane_sel),
  .result      (result),
  .carry_out   (carry_out),
  .out_valid   (out_valid)
);

// File: tb/test_savg_alu.sv
module test_savg_alu;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W      = 64;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [VEC_W-1:0] op_a = '0, op_b = '0;
  logic [2:0]       opcode = '0;
  logic             signed_mode = 1'b0;
  logic [1:0]       lane_sel = '0;
  logic [4:0]       shamt = '0;
  logic             carry_in = 1'b0;
  logic [VEC_W-1:0] result;
  logic             carry_out, out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  savg_alu #(.VEC_W(VEC_W)) i_savg_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .signed_mode(signed_mode), .lane_sel(lane_sel),
    .shamt(shamt), .carry_in(carry_in), .result(result),
    .carry_out(carry_out), .out_valid(out_valid)
  );

  function automatic longint unsigned pat(int lw, int k);
    longint unsigned m = (64'd1 << lw) - 64'd1;
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd2;
      3: return m;
      4: return 64'd1 << (lw - 1);
      5: return (64'd1 << (lw - 1)) - 64'd1;
      6: return 64'h5555_5555_5555_5555 & m;
      default: return m - 64'd1;
    endcase
  endfunction

  function automatic longint unsigned ref_lane(int op, bit sgn, int lw,
      longint unsigned a, longint unsigned b, int s);
    longint unsigned m = (64'd1 << lw) - 64'd1;
    longint ea, eb, pick, hi, lo, rnd;
    int se;
    ea = (sgn && a[lw-1]) ? longint'(a) - (longint'(1) << lw) : longint'(a);
    eb = (sgn && b[lw-1]) ? longint'(b) - (longint'(1) << lw) : longint'(b);
    se = (s > lw - 1) ? lw - 1 : s;
    rnd = (se > 0) ? (longint'(1) << (se - 1)) : 0;
    case (op)
      0: pick = ea + eb;
      1: pick = ea - eb;
      2: pick = (ea + eb) >>> 1;
      3: pick = (ea + eb + 1) >>> 1;
      4: pick = (ea - eb) >>> 1;
      5, 6: pick = (ea - eb + 1) >>> 1;
      default: pick = (ea + rnd) >>> se;
    endcase
    hi = sgn ? (longint'(1) << (lw - 1)) - 1 : (longint'(1) << lw) - 1;
    lo = sgn ? -(longint'(1) << (lw - 1)) : 0;
    if (op == 0 || op == 1 || op == 6) begin
      if (pick > hi) pick = hi;
      if (pick < lo) pick = lo;
    end
    return longint'(pick) & m;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0, 1: return "R6";
      2, 3: return "R7";
      4, 5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_vec(string tag, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drives one vector at a falling edge and checks it at the next one
  task automatic run_vec(int op, bit sgn, logic [1:0] sel, int ja, int jb, int sh, bit cin);
    int lw = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
    logic [VEC_W-1:0] va = '0, vb = '0, ve = '0;
    logic [32:0] csum;
    for (int i = 0; i < VEC_W / lw; i++) begin
      longint unsigned la = pat(lw, (ja + i) % 8);
      longint unsigned lb = pat(lw, (jb + 3 * i) % 8);
      va = va | (VEC_W'(la) << (i * lw));
      vb = vb | (VEC_W'(lb) << (i * lw));
      ve = ve | (VEC_W'(ref_lane(op, sgn, lw, la, lb, sh)) << (i * lw));
    end
    csum = {1'b0, va[31:0]} + {1'b0, vb[31:0]} + {32'd0, cin};
    in_valid = 1'b1; op_a = va; op_b = vb; opcode = 3'(op);
    signed_mode = sgn; lane_sel = sel; shamt = 5'(sh); carry_in = cin;
    @(negedge clk);
    // R4 R5: lanes checked together with the opcode requirement
    check_vec(op_tag(op), result, ve);
    check_bit("R11", carry_out, csum[32]);
    check_bit("R1", out_valid, 1'b1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [VEC_W-1:0] held;
    logic             held_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3
    check_vec("R3", result, '0);
    check_bit("R3", out_valid, 1'b0);
    check_bit("R3", carry_out, 1'b0);

    for (int g = 0; g < 3; g++)
      for (int op = 0; op < 8; op++)
        for (int sg = 0; sg < 2; sg++)
          for (int ja = 0; ja < 8; ja++)
            for (int jb = 0; jb < 8; jb++)
              run_vec(op, bit'(sg), 2'(g), ja, jb, (ja * 4 + jb) % 32, bit'((ja + jb) & 1));

    // R4: select value 3 behaves as 32-bit lanes
    for (int op = 0; op < 8; op++) run_vec(op, 1'b1, 2'd3, op, 7 - op, op * 5, 1'b1);

    // R2 and R1: idle cycles with changing inputs
    held = result;
    held_c = carry_out;
    in_valid = 1'b0;
    op_a = ~op_a; op_b = ~op_b; carry_in = ~carry_in; opcode = 3'd0;
    @(negedge clk);
    check_vec("R2", result, held);
    check_bit("R2", carry_out, held_c);
    check_bit("R1", out_valid, 1'b0);
    op_a = '1; op_b = '1;
    @(negedge clk);
    check_vec("R2", result, held);
    check_bit("R1", out_valid, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule